// File: doc/BRIEF.md
# Segmented Register Address Decoder

This block sits behind a host bus bridge and steers 32-bit register accesses to a set of accelerator register banks. The host presents a 17-bit word address together with a chip select, a write enable, a read enable and write data. The decoder splits the address into three fields: a segment that names the core family (hash, random-number or cipher), a core slot inside that segment, and a register offset inside that slot. It then sends the access to exactly one bank.

Slot 0 of the hash segment holds the board-wide registers: a board identifier, a bitstream version and one general-purpose scratch word. The other hash slots are simple register stubs. The random-number and cipher segments each carry one slot of placeholder scratch registers, so that the upper address bits can be exercised. A parameter mask switches each hash slot on or off. Any space with no register behind it drops writes and reads back as zero, and no error is signalled. Banks produce read data combinationally, and the decoder registers it, so a read returns its data on the clock after the request.

Top module: `seg_reg_decoder`

## Requirements
- R1: After synchronous reset, `rdata` is 0 and every writable register (global scratch, hash stubs, random-number and cipher dummies) reads back as 0.
- R2: The address fields are fixed: `addr[16:15]` is the segment (0 hash, 1 random-number, 2 cipher, 3 unmapped), `addr[14:8]` is the core slot and `addr[7:0]` is the register offset.
- R3: Hash slot 0 holds the board identifier at offset 0 and the version at offset 1, both read-only with values set by parameters (defaults 32'h00C0FFEE and 32'h00010002), plus a read/write scratch register at offset 2. Writes to offsets 0 and 1 leave them unchanged.
- R4: A read accepted on a clock edge (`cs` and `re` high) shows its data on `rdata` from that edge until the next edge. After an edge with no read, `rdata` is 0.
- R5: Each enabled hash slot from 1 to HASH_CORES-1 holds STUB_REGS (default 4) independent read/write 32-bit registers at offsets 0 to STUB_REGS-1.
- R6: A hash slot whose bit in HASH_EN is clear (default mask 4'b1011, so slot 2 is off) acts as unmapped space: its writes are dropped and its reads return 0.
- R7: Segment 3, core slots at or above a segment's slot count, and offsets past a bank's last register all discard writes and read as 0. There is no error output.
- R8: The random-number and cipher segments each hold, in slot 0, DUMMY_REGS (default 2) read/write registers. Their storage is separate from each other and from the hash segment at the same slot and offset.
- R9: A register changes only on an edge where `cs` and `we` are both high and the address selects it. At most one core slot in the whole block receives a write strobe in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Access select; gates all strobes |
| we | input | 1 | Write request |
| re | input | 1 | Read request |
| addr | input | 17 | Word address: segment, core slot, register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, one cycle after the request |

## Verification
On every cycle the assertions check that at most one segment and at most one core slot take a write strobe, that a register holds its value unless it is written, and that `rdata` returns to zero after any cycle with no read and stays zero after a read of segment 3. Other behaviour depends on stored contents, so only the bench scenarios can show it. These are the read-only global values, writes that are dropped for disabled slots, for slots or offsets out of range, or when `cs` is low, the separation of the random-number and cipher registers, and data returned by back-to-back reads.

// File: rtl/regdec_pkg.sv
package regdec_pkg;
  localparam int DATA_W   = 32;
  localparam int SEG_W    = 2;
  localparam int CORE_W   = 7;
  localparam int OFF_W    = 8;
  localparam int ADDR_W   = SEG_W + CORE_W + OFF_W;
  localparam int CORE_LSB = OFF_W;
  localparam int SEG_LSB  = OFF_W + CORE_W;

  typedef enum logic [SEG_W-1:0] {
    SEG_HASH   = 2'd0,
    SEG_RNG    = 2'd1,
    SEG_CIPHER = 2'd2,
    SEG_NONE   = 2'd3
  } seg_e;

  localparam logic [OFF_W-1:0] GOFF_BOARD   = 8'd0;
  localparam logic [OFF_W-1:0] GOFF_VERSION = 8'd1;
  localparam logic [OFF_W-1:0] GOFF_SCRATCH = 8'd2;
endpackage

// File: rtl/regdec_scratch_bank.sv
module regdec_scratch_bank
  import regdec_pkg::*;
#(
  parameter int NREGS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data
);
  logic [NREGS-1:0][DATA_W-1:0] regs;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < NREGS; r++) begin
        if (off == OFF_W'(r)) regs[r] <= wdata;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NREGS; r++) begin
      if (off == OFF_W'(r)) rd_data = regs[r];
    end
  end

  // R9
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs));
endmodule

// File: rtl/regdec_global_bank.sv
module regdec_global_bank
  import regdec_pkg::*;
#(
  parameter logic [DATA_W-1:0] BOARD_ID = 32'h00C0FFEE,
  parameter logic [DATA_W-1:0] VERSION  = 32'h00010002
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] scratch;

  always_ff @(posedge clk) begin
    if (rst) begin
      scratch <= '0;
    end else if (wr_en && off == GOFF_SCRATCH) begin
      scratch <= wdata;
    end
  end

  always_comb begin
    case (off)
      GOFF_BOARD:   rd_data = BOARD_ID;
      GOFF_VERSION: rd_data = VERSION;
      GOFF_SCRATCH: rd_data = scratch;
      default:      rd_data = '0;
    endcase
  end

  // R3
  global_scratch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && off == GOFF_SCRATCH) |=> $stable(scratch));
endmodule

// File: rtl/regdec_segment.sv
module regdec_segment
  import regdec_pkg::*;
#(
  parameter int                 NCORES   = 4,
  parameter logic [NCORES-1:0]  EN       = '1,
  parameter int                 NREGS    = 4,
  parameter bit                 GLOBAL   = 1'b0,
  parameter logic [DATA_W-1:0]  BOARD_ID = 32'h00C0FFEE,
  parameter logic [DATA_W-1:0]  VERSION  = 32'h00010002
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [CORE_W-1:0] core,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data
);
  logic [NCORES-1:0]             core_hit;
  logic [NCORES-1:0]             core_wr;
  logic [NCORES-1:0][DATA_W-1:0] core_rd;

  for (genvar i = 0; i < NCORES; i++) begin : g_slot
    assign core_hit[i] = sel && EN[i] && (core == CORE_W'(i));
    assign core_wr[i]  = core_hit[i] && we;

    if (GLOBAL && i == 0) begin : g_global
      regdec_global_bank #(
        .BOARD_ID (BOARD_ID),
        .VERSION  (VERSION)
      ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (core_wr[i]),
        .off     (off),
        .wdata   (wdata),
        .rd_data (core_rd[i])
      );
    end else if (EN[i]) begin : g_stub
      regdec_scratch_bank #(
        .NREGS (NREGS)
      ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (core_wr[i]),
        .off     (off),
        .wdata   (wdata),
        .rd_data (core_rd[i])
      );
    end else begin : g_off
      assign core_rd[i] = '0;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCORES; i++) begin
      if (core_hit[i]) rd_data = core_rd[i];
    end
  end

  // R9
  one_core_wr_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(core_wr));
endmodule

// File: rtl/seg_reg_decoder.sv
module seg_reg_decoder
  import regdec_pkg::*;
#(
  parameter int                    HASH_CORES   = 4,
  parameter logic [HASH_CORES-1:0] HASH_EN      = 4'b1011,
  parameter int                    STUB_REGS    = 4,
  parameter int                    RNG_CORES    = 1,
  parameter int                    CIPHER_CORES = 1,
  parameter int                    DUMMY_REGS   = 2,
  parameter logic [31:0]           BOARD_ID     = 32'h00C0FFEE,
  parameter logic [31:0]           VERSION      = 32'h00010002
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cs,
  input  logic        we,
  input  logic        re,
  input  logic [16:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam int NSEG = 3;

  seg_e              seg;
  logic [CORE_W-1:0] core;
  logic [OFF_W-1:0]  off;
  logic [NSEG-1:0]   seg_sel;
  logic [NSEG-1:0][DATA_W-1:0] seg_rd;
  logic [DATA_W-1:0] rd_mux;

  assign seg  = seg_e'(addr[SEG_LSB +: SEG_W]);
  assign core = addr[CORE_LSB +: CORE_W];
  assign off  = addr[0 +: OFF_W];

  assign seg_sel[0] = cs && (seg == SEG_HASH);
  assign seg_sel[1] = cs && (seg == SEG_RNG);
  assign seg_sel[2] = cs && (seg == SEG_CIPHER);

  regdec_segment #(
    .NCORES   (HASH_CORES),
    .EN       (HASH_EN),
    .NREGS    (STUB_REGS),
    .GLOBAL   (1'b1),
    .BOARD_ID (BOARD_ID),
    .VERSION  (VERSION)
  ) u_hash (
    .clk (clk), .rst (rst), .sel (seg_sel[0]), .we (we),
    .core (core), .off (off), .wdata (wdata), .rd_data (seg_rd[0])
  );

  regdec_segment #(
    .NCORES (RNG_CORES),
    .EN     ({RNG_CORES{1'b1}}),
    .NREGS  (DUMMY_REGS),
    .GLOBAL (1'b0)
  ) u_rng (
    .clk (clk), .rst (rst), .sel (seg_sel[1]), .we (we),
    .core (core), .off (off), .wdata (wdata), .rd_data (seg_rd[1])
  );

  regdec_segment #(
    .NCORES (CIPHER_CORES),
    .EN     ({CIPHER_CORES{1'b1}}),
    .NREGS  (DUMMY_REGS),
    .GLOBAL (1'b0)
  ) u_cipher (
    .clk (clk), .rst (rst), .sel (seg_sel[2]), .we (we),
    .core (core), .off (off), .wdata (wdata), .rd_data (seg_rd[2])
  );

  always_comb begin
    rd_mux = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (seg_sel[s]) rd_mux = seg_rd[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= (cs && re) ? rd_mux : '0;
    end
  end

  // R9
  one_seg_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(seg_sel));

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(cs && re) |=> rdata == '0);

  // R7
  unmapped_seg_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && re && addr[16:15] == 2'd3) |=> rdata == '0);
endmodule

// File: tb/seg_reg_decoder_bench.sv
module seg_reg_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs = 1'b0, we = 1'b0, re = 1'b0;
  logic [16:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  logic rd_pend = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [31:0] BOARD = 32'h00C0FFEE;
  localparam logic [31:0] VER   = 32'h00010002;

  always #5 clk = ~clk;

  seg_reg_decoder u_seg_reg_decoder (
    .clk (clk), .rst (rst), .cs (cs), .we (we), .re (re),
    .addr (addr), .wdata (wdata), .rdata (rdata)
  );

  function automatic logic [16:0] mk(input logic [1:0] s, input int c, input int o);
    return {s, 7'(c), 8'(o)};
  endfunction

  function automatic void check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  // monitor: read accepted on an edge -> compare at the following negedge
  always @(posedge clk) rd_pend <= !rst && cs && re;

  always @(negedge clk) begin
    if (mon_on) begin
      if (rd_pend) begin
        if (exp_q.size() == 0) begin
          check("R4 unexpected read data", rdata, 32'hXXXXXXXX);
        end else begin
          check(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
      end else begin
        check("R4 idle zero", rdata, 32'h0);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    cs = 1'b0; we = 1'b0; re = 1'b0;
  endtask

  task automatic wr(input logic [16:0] a, input logic [31:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs = sel; we = 1'b1; re = 1'b0; addr = a; wdata = d;
    idle();
  endtask

  task automatic rd_issue(input logic [16:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; re = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic rd(input logic [16:0] a, input logic [31:0] e, input string tag);
    rd_issue(a, e, tag);
    idle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata after reset", rdata, 32'h0);
    mon_on = 1'b1;

    // R1 reset contents
    rd(mk(0, 0, 2), 32'h0, "R1 global scratch reset");
    rd(mk(0, 1, 3), 32'h0, "R1 hash stub reset");
    rd(mk(1, 0, 1), 32'h0, "R1 rng dummy reset");
    rd(mk(2, 0, 0), 32'h0, "R1 cipher dummy reset");

    // R3 global bank
    rd(mk(0, 0, 0), BOARD, "R3 board id");
    rd(mk(0, 0, 1), VER, "R3 version");
    wr(mk(0, 0, 0), 32'hDEAD0000);
    wr(mk(0, 0, 1), 32'hDEAD0001);
    wr(mk(0, 0, 2), 32'h5A5A1234);
    rd(mk(0, 0, 0), BOARD, "R3 board id read-only");
    rd(mk(0, 0, 1), VER, "R3 version read-only");
    rd(mk(0, 0, 2), 32'h5A5A1234, "R3 scratch read/write");

    // R5 hash stubs
    for (int r = 0; r < 4; r++) wr(mk(0, 1, r), 32'h1100_0000 + r);
    wr(mk(0, 3, 1), 32'h3300_0001);
    for (int r = 0; r < 4; r++) rd(mk(0, 1, r), 32'h1100_0000 + r, "R5 slot1 register");
    rd(mk(0, 3, 1), 32'h3300_0001, "R5 slot3 register");
    rd(mk(0, 3, 0), 32'h0, "R5 slot3 untouched register");

    // R4 back-to-back reads
    rd_issue(mk(0, 1, 2), 32'h1100_0002, "R4 back-to-back first");
    rd_issue(mk(0, 0, 0), BOARD, "R4 back-to-back second");
    rd_issue(mk(0, 3, 1), 32'h3300_0001, "R4 back-to-back third");
    idle();

    // R6 disabled slot
    wr(mk(0, 2, 0), 32'h2222_2222);
    rd(mk(0, 2, 0), 32'h0, "R6 disabled slot");

    // R7 unmapped space
    wr(mk(0, 5, 0), 32'h5555_5555);
    rd(mk(0, 5, 0), 32'h0, "R7 slot beyond count");
    wr(mk(0, 1, 4), 32'h4444_4444);
    rd(mk(0, 1, 4), 32'h0, "R7 offset beyond bank");
    rd(mk(0, 1, 0), 32'h1100_0000, "R7 neighbour intact");
    wr(mk(3, 0, 0), 32'h3333_3333);
    rd(mk(3, 0, 0), 32'h0, "R7 segment 3");
    rd(mk(0, 0, 8), 32'h0, "R7 global offset beyond");

    // R8 rng / cipher separation, R2 field positions
    wr(mk(1, 0, 0), 32'hAAAA_0000);
    wr(mk(1, 0, 1), 32'hAAAA_0001);
    wr(mk(2, 0, 1), 32'hCCCC_0001);
    rd(mk(1, 0, 0), 32'hAAAA_0000, "R8 rng reg0");
    rd(mk(1, 0, 1), 32'hAAAA_0001, "R8 rng reg1");
    rd(mk(2, 0, 1), 32'hCCCC_0001, "R8 cipher reg1");
    rd(mk(2, 0, 0), 32'h0, "R8 cipher reg0 untouched");
    rd(mk(1, 0, 2), 32'h0, "R8 rng offset beyond");
    rd(17'h08100, 32'h0, "R2 rng slot1 unmapped");
    rd(17'h00101, 32'h1100_0001, "R2 raw address hash slot1 off1");
    rd(mk(0, 0, 2), 32'h5A5A1234, "R8 hash scratch unaffected");

    // R9 write gating
    wr(mk(0, 1, 0), 32'hBAD0_BAD0, 1'b0);
    rd(mk(0, 1, 0), 32'h1100_0000, "R9 write with cs low");
    @(negedge clk);
    cs = 1'b1; we = 1'b0; re = 1'b0; addr = mk(0, 0, 2); wdata = 32'hBAD1_BAD1;
    idle();
    rd(mk(0, 0, 2), 32'h5A5A1234, "R9 cs without we");

    repeat (3) @(negedge clk);
    done = 1'b1;
    if (exp_q.size() != 0) check("R4 reads left unanswered", 32'(exp_q.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule